// File: doc/BRIEF.md
# Sample FIFO with Coded Attention Threshold

This block is a synchronous first-in first-out buffer for audio sample words. It sits between a host-side port and a serial engine. One parameter picks the transmit variant, which the host fills and the serializer drains. The other setting is the receive variant, which the deserializer fills and the host drains. A second parameter picks between the large sample-data buffer, 16 entries by default, and a small user-data buffer of 4 entries.

Each instance reports a 5-bit count and an attention flag. The receive variant counts occupied slots, and attention means the count has reached the threshold. The transmit variant counts free slots, and attention means that many slots can be filled. A 2-bit code sets the threshold. For the data buffer the code maps onto the non-linear set 1, 4, 8, 12. For the user buffer the code maps linearly onto 1 to 4. A clear input empties the buffer at once.

Occupancy is tracked by a state machine with three states: `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. The transitions are:
- EMPTY to PARTIAL on an accepted push.
- PARTIAL to FULL when the next occupancy reaches the depth.
- PARTIAL to EMPTY when the next occupancy reaches zero.
- FULL to PARTIAL on an accepted pop.
- Any state to EMPTY on clear.

Top module: `sample_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty_o`=1, `full_o`=0, `overrun_o`=0, `underrun_o`=0, and `count_o` reads 0 (receive) or DEPTH (transmit).
- R2: Words leave in the order they were accepted. The word for a pop strobe sampled at a rising edge appears on `pop_data_o` after that edge.
- R3: `count_o` is a 5-bit field. The receive variant reports the number of occupied slots and the transmit variant reports DEPTH minus that number. Both update after the edge that accepts a push or pop.
- R4: With `LINEAR_CODE`=0, `lvl_code_i` values 0, 1, 2, 3 select thresholds of 1, 4, 8 and 12 slots.
- R5: With `LINEAR_CODE`=1, `lvl_code_i` value c selects a threshold of c+1 slots.
- R6: `attn_o` is 1 exactly when the reported count is at least the threshold. It follows `lvl_code_i` combinationally and changes in the same cycle as `count_o`.
- R7: `full_o` is 1 exactly when all DEPTH slots are occupied. `empty_o` is 1 exactly when none are occupied.
- R8: A push while full is dropped and leaves the contents and count unchanged. `overrun_o` is 1 for the one cycle after that edge.
- R9: A pop while empty leaves `pop_data_o` holding its last word. `underrun_o` is 1 for the one cycle after that edge.
- R10: `clr_i` empties the buffer at the next edge and overrides any push or pop in the same cycle. Neither `overrun_o` nor `underrun_o` is raised by that cycle.
- R11: A simultaneous push and pop on a partly filled buffer leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear, empties the buffer |
| lvl_code_i | input | 2 | Attention threshold code |
| push_i | input | 1 | Write strobe |
| push_data_i | input | DATA_W | Word to write |
| full_o | output | 1 | All slots occupied |
| pop_i | input | 1 | Read strobe |
| pop_data_o | output | DATA_W | Last word read |
| empty_o | output | 1 | No slot occupied |
| count_o | output | CNT_W | Occupied (receive) or free (transmit) slots |
| attn_o | output | 1 | Count has reached the coded threshold |
| overrun_o | output | 1 | Pulse after a push that was dropped because the buffer was full |
| underrun_o | output | 1 | Pulse after a pop attempted while the buffer was empty |

## Verification
A receive and a transmit data instance, plus a receive user instance, share one stimulus stream. This lets a single walk show that the two variants report opposite counts and opposite attention senses. A table of fill and drain steps sweeps the occupancy across every data threshold, with the code changed at counts just below, at and above each one. This separates the non-linear mapping from a linear one and shows where a strict or off-by-one compare would fail. The same stream overfills the 4-entry user instance and drains it past empty, so its linear mapping, drop behaviour and data order are checked alongside. Directed steps follow for:
- pushing into a full buffer;
- popping an empty one;
- a simultaneous push and pop;
- a clear combined with a push, both on a partly filled buffer and on a full one.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } occ_state_e;

    // Non-linear threshold set for the large sample buffer: 1, 4, 8, 12
    function automatic logic [4:0] coded_slots(input logic [1:0] code);
        logic [4:0] slots;
        if (code == 2'd0) slots = 5'd1;
        else              slots = {1'b0, code, 2'b00};
        return slots;
    endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // Read word register holds its value whenever no pop is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_ptr];
    end

endmodule

// File: rtl/sfifo_occ.sv
module sfifo_occ
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned OCW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic           pop,
    output logic           acc_push,
    output logic           acc_pop,
    output logic [OCW-1:0] occ,
    output logic           full,
    output logic           empty,
    output logic           overrun,
    output logic           underrun
);

    occ_state_e     state_q;
    occ_state_e     state_d;
    logic [OCW-1:0] occ_d;

    assign acc_push = push && !clr && (state_q != ST_FULL);
    assign acc_pop  = pop  && !clr && (state_q != ST_EMPTY);

    always_comb begin
        if (clr) occ_d = '0;
        else     occ_d = occ + OCW'(acc_push) - OCW'(acc_pop);
    end

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (acc_push)
                        state_d = (occ_d == OCW'(DEPTH)) ? ST_FULL : ST_PARTIAL;
                end
                ST_PARTIAL: begin
                    if (occ_d == OCW'(DEPTH)) state_d = ST_FULL;
                    else if (occ_d == '0)     state_d = ST_EMPTY;
                end
                ST_FULL: begin
                    if (acc_pop)
                        state_d = (occ_d == '0) ? ST_EMPTY : ST_PARTIAL;
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    // State and occupancy registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            occ     <= '0;
        end else begin
            state_q <= state_d;
            occ     <= occ_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            ST_EMPTY:   empty = 1'b1;
            ST_PARTIAL: ;
            ST_FULL:    full  = 1'b1;
            default:    empty = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            overrun  <= push && !clr && (state_q == ST_FULL);
            underrun <= pop  && !clr && (state_q == ST_EMPTY);
        end
    end

    AST_FULL_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) == (occ == OCW'(DEPTH))); // R7
    AST_EMPTY_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY) == (occ == '0)); // R7
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (occ == '0) && (state_q == ST_EMPTY)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr && full) |=> $stable(occ) && overrun); // R8
    AST_PUSHPOP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !clr && state_q == ST_PARTIAL) |=> $stable(occ)); // R11

endmodule

// File: rtl/sfifo_attn.sv
module sfifo_attn
    import sfifo_pkg::*;
#(
    parameter int unsigned DEPTH       = 16,
    parameter bit          IS_TX       = 1'b0,
    parameter bit          LINEAR_CODE = 1'b0,
    parameter int unsigned CNT_W       = 5,
    localparam int unsigned OCW        = $clog2(DEPTH + 1)
) (
    input  logic [OCW-1:0]   occ,
    input  logic [1:0]       code,
    output logic [CNT_W-1:0] count,
    output logic             attn
);

    logic [CNT_W-1:0] thr;

    generate
        if (IS_TX) begin : g_free
            assign count = CNT_W'(DEPTH) - CNT_W'(occ);
        end else begin : g_used
            assign count = CNT_W'(occ);
        end

        if (LINEAR_CODE) begin : g_linear
            assign thr = CNT_W'(code) + CNT_W'(1);
        end else begin : g_coded
            assign thr = CNT_W'(coded_slots(code));
        end
    endgenerate

    assign attn = (count >= thr);

endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned DEPTH       = 16,
    parameter bit          IS_TX       = 1'b0,
    parameter bit          LINEAR_CODE = 1'b0,
    parameter int unsigned CNT_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [1:0]        lvl_code_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic              full_o,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    output logic              empty_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              attn_o,
    output logic              overrun_o,
    output logic              underrun_o
);

    localparam int unsigned OCW = $clog2(DEPTH + 1);

    logic           acc_push;
    logic           acc_pop;
    logic [OCW-1:0] occ;

    sfifo_occ #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_i),
        .push     (push_i),
        .pop      (pop_i),
        .acc_push (acc_push),
        .acc_pop  (acc_pop),
        .occ      (occ),
        .full     (full_o),
        .empty    (empty_o),
        .overrun  (overrun_o),
        .underrun (underrun_o)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_i),
        .wr_en   (acc_push),
        .wr_data (push_data_i),
        .rd_en   (acc_pop),
        .rd_data (pop_data_o)
    );

    sfifo_attn #(
        .DEPTH       (DEPTH),
        .IS_TX       (IS_TX),
        .LINEAR_CODE (LINEAR_CODE),
        .CNT_W       (CNT_W)
    ) u_attn (
        .occ   (occ),
        .code  (lvl_code_i),
        .count (count_o),
        .attn  (attn_o)
    );

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH)); // R3
    AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !clr_i) |=> $stable(pop_data_o) && underrun_o); // R9
    AST_CLR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !overrun_o && !underrun_o); // R10

endmodule

// File: tb/sample_fifo_tb.sv
module sample_fifo_tb;

    localparam int W = 24;
    localparam int DD = 16;
    localparam int UD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, push = 1'b0, pop = 1'b0;
    logic [1:0] code = 2'd0;
    logic [W-1:0] din = '0;

    always #10 clk = ~clk;

    logic [W-1:0] rd_rx, rd_tx, rd_us;
    logic full_rx, full_tx, full_us, emp_rx, emp_tx, emp_us;
    logic [4:0] cnt_rx, cnt_tx, cnt_us;
    logic at_rx, at_tx, at_us, ov_rx, ov_tx, ov_us, un_rx, un_tx, un_us;

    sample_fifo #(.DATA_W(W), .DEPTH(DD), .IS_TX(1'b0), .LINEAR_CODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .lvl_code_i(code), .push_i(push),
        .push_data_i(din), .full_o(full_rx), .pop_i(pop), .pop_data_o(rd_rx),
        .empty_o(emp_rx), .count_o(cnt_rx), .attn_o(at_rx), .overrun_o(ov_rx),
        .underrun_o(un_rx));

    sample_fifo #(.DATA_W(W), .DEPTH(DD), .IS_TX(1'b1), .LINEAR_CODE(1'b0)) u_dut_tx (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .lvl_code_i(code), .push_i(push),
        .push_data_i(din), .full_o(full_tx), .pop_i(pop), .pop_data_o(rd_tx),
        .empty_o(emp_tx), .count_o(cnt_tx), .attn_o(at_tx), .overrun_o(ov_tx),
        .underrun_o(un_tx));

    sample_fifo #(.DATA_W(W), .DEPTH(UD), .IS_TX(1'b0), .LINEAR_CODE(1'b1)) u_dut_usr (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .lvl_code_i(code), .push_i(push),
        .push_data_i(din), .full_o(full_us), .pop_i(pop), .pop_data_o(rd_us),
        .empty_o(emp_us), .count_o(cnt_us), .attn_o(at_us), .overrun_o(ov_us),
        .underrun_o(un_us));

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [W-1:0] seq = 24'h100;

    // Reference queues and last-read words
    logic [W-1:0] q16[$];
    logic [W-1:0] q4[$];
    logic [W-1:0] last16 = '0;
    logic [W-1:0] last4 = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock cycle of stimulus; called at a falling edge, returns at the next one
    task automatic cyc(input bit p, input bit q, input bit c, input logic [W-1:0] d);
        int sb16, sb4;
        push = p; pop = q; clr = c; din = d;
        @(posedge clk);
        sb16 = q16.size();
        sb4  = q4.size();
        if (c) begin
            q16.delete();
            q4.delete();
        end else begin
            if (q && sb16 > 0) last16 = q16.pop_front();
            if (q && sb4 > 0)  last4  = q4.pop_front();
            if (p && sb16 < DD) q16.push_back(d);
            if (p && sb4 < UD)  q4.push_back(d);
        end
        @(negedge clk);
        push = 1'b0; pop = 1'b0; clr = 1'b0;
        if (q && !c) begin
            chk(rd_rx == last16, "R2", "rx pop word", rd_rx, last16);
            chk(rd_tx == last16, "R2", "tx pop word", rd_tx, last16);
            chk(rd_us == last4,  "R2", "user pop word", rd_us, last4);
        end
    endtask

    // Row: npush, npop, code, expected rx count, rx attn, tx attn
    localparam logic [18:0] VEC [12] = '{
        {5'd1, 5'd0, 2'd0, 5'd1,  1'b1, 1'b1},
        {5'd3, 5'd0, 2'd1, 5'd4,  1'b1, 1'b1},
        {5'd0, 5'd0, 2'd2, 5'd4,  1'b0, 1'b1},
        {5'd4, 5'd0, 2'd2, 5'd8,  1'b1, 1'b1},
        {5'd1, 5'd0, 2'd2, 5'd9,  1'b1, 1'b0},
        {5'd0, 5'd0, 2'd3, 5'd9,  1'b0, 1'b0},
        {5'd3, 5'd0, 2'd3, 5'd12, 1'b1, 1'b0},
        {5'd4, 5'd0, 2'd3, 5'd16, 1'b1, 1'b0},
        {5'd0, 5'd0, 2'd0, 5'd16, 1'b1, 1'b0},
        {5'd0, 5'd5, 2'd1, 5'd11, 1'b1, 1'b1},
        {5'd0, 5'd8, 2'd1, 5'd3,  1'b0, 1'b1},
        {5'd0, 5'd3, 2'd0, 5'd0,  1'b0, 1'b1}
    };

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(emp_rx == 1'b1 && full_rx == 1'b0, "R1", "rx empty/full", {emp_rx, full_rx}, 2'b10);
        chk(cnt_rx == 5'd0, "R1", "rx count", cnt_rx, 0);
        chk(cnt_tx == 5'd16, "R1", "tx count", cnt_tx, 16);
        chk(cnt_us == 5'd0, "R1", "user count", cnt_us, 0);
        chk(at_rx == 1'b0 && at_tx == 1'b1, "R1", "attn rx/tx", {at_rx, at_tx}, 2'b01);
        chk({ov_rx, un_rx, ov_tx, un_tx} == 4'b0, "R1", "pulses", {ov_rx, un_rx, ov_tx, un_tx}, 0);

        // Table walk: R3, R4, R5, R6, R7
        for (int i = 0; i < 12; i++) begin
            logic [18:0] row;
            int ec;
            row = VEC[i];
            code = row[8:7];
            for (int k = 0; k < int'(row[18:14]); k++) begin
                cyc(1'b1, 1'b0, 1'b0, seq);
                seq++;
            end
            for (int k = 0; k < int'(row[13:9]); k++) cyc(1'b0, 1'b1, 1'b0, '0);
            if (row[18:9] == '0) cyc(1'b0, 1'b0, 1'b0, '0);
            ec = int'(row[6:2]);
            chk(cnt_rx == 5'(ec), "R3", "rx count", cnt_rx, ec);
            chk(cnt_tx == 5'(DD - ec), "R3", "tx count", cnt_tx, DD - ec);
            chk(at_rx == row[1], "R4", "rx attn coded", at_rx, row[1]);
            chk(at_tx == row[0], "R6", "tx attn free sense", at_tx, row[0]);
            chk(cnt_us == 5'(q4.size()), "R5", "user count", cnt_us, q4.size());
            chk(at_us == (q4.size() >= int'(code) + 1), "R5", "user attn linear",
                at_us, (q4.size() >= int'(code) + 1));
            chk(full_rx == (ec == DD) && emp_rx == (ec == 0), "R7", "rx full/empty",
                {full_rx, emp_rx}, {(ec == DD), (ec == 0)});
        end

        // R8 overrun: fill, push once more
        for (int k = 0; k < DD; k++) begin
            cyc(1'b1, 1'b0, 1'b0, seq);
            seq++;
        end
        chk(full_rx == 1'b1 && full_tx == 1'b1, "R7", "full after fill", {full_rx, full_tx}, 2'b11);
        cyc(1'b1, 1'b0, 1'b0, 24'hABCDEF);
        chk(ov_rx == 1'b1 && ov_tx == 1'b1, "R8", "overrun pulse", {ov_rx, ov_tx}, 2'b11);
        chk(cnt_rx == 5'd16 && cnt_tx == 5'd0, "R8", "count after drop", cnt_rx, 16);
        cyc(1'b0, 1'b0, 1'b0, '0);
        chk(ov_rx == 1'b0, "R8", "overrun single cycle", ov_rx, 0);
        for (int k = 0; k < DD; k++) cyc(1'b0, 1'b1, 1'b0, '0);

        // R9 underrun: pop while empty
        cyc(1'b0, 1'b1, 1'b0, '0);
        chk(un_rx == 1'b1 && un_us == 1'b1, "R9", "underrun pulse", {un_rx, un_us}, 2'b11);
        chk(rd_rx == last16, "R9", "held word", rd_rx, last16);
        cyc(1'b0, 1'b0, 1'b0, '0);
        chk(un_rx == 1'b0, "R9", "underrun single cycle", un_rx, 0);

        // R11 push and pop together on a partial buffer
        cyc(1'b1, 1'b0, 1'b0, seq); seq++;
        cyc(1'b1, 1'b0, 1'b0, seq); seq++;
        cyc(1'b1, 1'b1, 1'b0, seq); seq++;
        chk(cnt_rx == 5'd2 && cnt_tx == 5'd14, "R11", "count kept", cnt_rx, 2);

        // R10 clear with push on a partial buffer
        cyc(1'b1, 1'b1, 1'b1, seq); seq++;
        chk(cnt_rx == 5'd0 && cnt_tx == 5'd16 && cnt_us == 5'd0, "R10", "count after clear", cnt_rx, 0);
        chk(emp_rx == 1'b1 && {ov_rx, un_rx} == 2'b00, "R10", "empty no pulse",
            {emp_rx, ov_rx, un_rx}, 3'b100);

        // R10 clear with push on a full buffer
        for (int k = 0; k < DD; k++) begin
            cyc(1'b1, 1'b0, 1'b0, seq);
            seq++;
        end
        cyc(1'b1, 1'b0, 1'b1, seq); seq++;
        chk(ov_rx == 1'b0 && cnt_rx == 5'd0 && emp_rx == 1'b1, "R10", "clear beats full push",
            {ov_rx, cnt_rx}, 0);

        // R5, R4 and R6: code sweep at occupancy 2
        cyc(1'b1, 1'b0, 1'b0, seq); seq++;
        cyc(1'b1, 1'b0, 1'b0, seq); seq++;
        for (int c = 0; c < 4; c++) begin
            code = 2'(c);
            #2;
            chk(at_us == (c + 1 <= 2), "R5", "user attn sweep", at_us, (c + 1 <= 2));
            chk(at_rx == (c == 0), "R4", "rx attn sweep", at_rx, (c == 0));
            chk(at_tx == 1'b1, "R6", "tx attn sweep", at_tx, 1);
        end
        @(negedge clk);
        cyc(1'b0, 1'b1, 1'b0, '0);
        cyc(1'b0, 1'b1, 1'b0, '0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule